// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block works out which of eight DRAM rows holds a given physical byte address. Each row has an 8-bit boundary register. The register holds the row's upper limit as a cumulative value, not the row's size. One unit of the register is 8 MiB. A row starts where the row below it ends, and row 0 starts at address zero. When a row's effective limit is the same as the running limit of the rows below it, the row holds no memory. When a register reads zero while the running limit is already nonzero, that row's limit is the 2 GiB top of memory.

Software or boot logic loads the registers through a plain write port that is one byte wide. After that, the memory controller sends lookup requests with an address. For each request the block returns a row number and a hit flag, registered, one cycle later. The block also drives, without a clock delay, an empty flag for each row and the inclusive first and last byte address of each row. Error logging uses these to turn a faulting address into a row.

Top module: `dram_row_decoder`

## Requirements
- R1: After reset, every boundary register is zero, every row is flagged empty with base and last both 0, `rsp_valid` is low, and every lookup returns `rsp_hit`=0 with `rsp_row`=0.
- R2: A cycle with `wr_en` high stores `wr_data` into register number `wr_idx`, from 0 to 7. A nonzero register value v gives its row a limit of v·2^23 bytes, so the value 255 gives 0x7F800000.
- R3: A non-empty row reports `row_base` equal to the running limit of the rows below it (0 for row 0) and `row_last` equal to its own limit minus one. Both are 32-bit byte addresses, and row r sits in bits [32r+31:32r] of the flat vector.
- R4: A row whose effective limit equals the running limit is empty. Its bit r of `row_empty` is 1, it reports base 0 and last 0, it leaves the running limit unchanged, and no lookup ever hits it.
- R5: A register reading zero while the running limit is nonzero gives its row the limit 2^31, so its last address is 0x7FFFFFFF. A later zero register then yields an empty row.
- R6: An address that falls in no non-empty row, including any address at or above the highest limit, returns `rsp_hit`=0 and `rsp_row`=0.
- R7: When limits are programmed out of order and rows overlap, a lookup returns the lowest-numbered non-empty row r with base(r) ≤ address < limit(r).
- R8: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high and is low otherwise. `rsp_row` and `rsp_hit` change only together with a response.
- R9: A lookup made in the same cycle as a register write is decoded against the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Boundary register write strobe |
| wr_idx | input | 3 | Number of the register to write |
| wr_data | input | 8 | Boundary value in 8 MiB units |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Byte address to decode |
| rsp_valid | output | 1 | Lookup result valid, one cycle after the request |
| rsp_row | output | 3 | Decoded row number, 0 on a miss |
| rsp_hit | output | 1 | Address lies in a non-empty row |
| row_empty | output | 8 | One flag per row, set when the row holds no memory |
| row_base | output | 256 | Per-row first byte address, row r at bits [32r+31:32r] |
| row_last | output | 256 | Per-row last byte address, row r at bits [32r+31:32r] |

## Verification
The assertions check four things on every cycle. A response appears exactly one cycle after each request and at no other time. A miss always returns row 0. A hit never names a row that was empty when the request was taken. A write to row 0 immediately sets or clears that row's empty flag. Only the bench's scenarios can show that the arithmetic is right: the 8 MiB scaling, the running bases, the substitution of 2^31 for a zero register, the empty rows inside a populated map, and the lowest-row priority when out-of-order limits overlap. The bench compares each of these against its own model on every cycle.

// File: rtl/dram_row_pkg.sv
package dram_row_pkg;
   localparam int unsigned ROWS_DEF   = 8;
   localparam int unsigned BND_W_DEF  = 8;
   localparam int unsigned SHIFT_DEF  = 23;
   localparam int unsigned ADDR_W_DEF = 32;
endpackage

// File: rtl/drow_bnd_regs.sv
module drow_bnd_regs #(
   parameter int unsigned NUM_ROWS = dram_row_pkg::ROWS_DEF,
   parameter int unsigned BND_W    = dram_row_pkg::BND_W_DEF,
   parameter int unsigned IDX_W    = $clog2(NUM_ROWS)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [IDX_W-1:0]                 wr_idx,
   input  logic [BND_W-1:0]                 wr_data,
   output logic [NUM_ROWS-1:0][BND_W-1:0]   bnd_o
);
   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bnd_o[r] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(r)))
            bnd_o[r] <= wr_data;
      end
   end
endmodule

// File: rtl/drow_limit_chain.sv
module drow_limit_chain #(
   parameter int unsigned NUM_ROWS = dram_row_pkg::ROWS_DEF,
   parameter int unsigned BND_W    = dram_row_pkg::BND_W_DEF,
   parameter int unsigned SHIFT    = dram_row_pkg::SHIFT_DEF,
   parameter int unsigned ADDR_W   = dram_row_pkg::ADDR_W_DEF
) (
   input  logic [NUM_ROWS-1:0][BND_W-1:0]  bnd_i,
   output logic [NUM_ROWS-1:0][ADDR_W-1:0] lim_o,
   output logic [NUM_ROWS-1:0][ADDR_W-1:0] base_o,
   output logic [NUM_ROWS-1:0][ADDR_W-1:0] last_o,
   output logic [NUM_ROWS-1:0]             empty_o
);
   localparam int unsigned LIM_W = BND_W + SHIFT + 1;
   localparam logic [LIM_W-1:0] TOP_V = {1'b1, {(LIM_W-1){1'b0}}};

   // running limit seen by each row; entry 0 is the bottom of memory
   logic [NUM_ROWS:0][LIM_W-1:0] run;
   assign run[0] = '0;

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      logic [LIM_W-1:0] raw;
      logic [LIM_W-1:0] eff;
      assign raw        = {1'b0, bnd_i[r], {SHIFT{1'b0}}};
      assign eff        = ((run[r] != '0) && (bnd_i[r] == '0)) ? TOP_V : raw;
      assign empty_o[r] = (eff == run[r]);
      assign run[r+1]   = eff;
      assign lim_o[r]   = ADDR_W'(eff);
      assign base_o[r]  = empty_o[r] ? '0 : ADDR_W'(run[r]);
      assign last_o[r]  = empty_o[r] ? '0 : ADDR_W'(eff - 1'b1);
   end
endmodule

// File: rtl/drow_match.sv
module drow_match #(
   parameter int unsigned NUM_ROWS = dram_row_pkg::ROWS_DEF,
   parameter int unsigned ADDR_W   = dram_row_pkg::ADDR_W_DEF,
   parameter int unsigned IDX_W    = $clog2(NUM_ROWS)
) (
   input  logic [ADDR_W-1:0]               addr_i,
   input  logic [NUM_ROWS-1:0][ADDR_W-1:0] lim_i,
   input  logic [NUM_ROWS-1:0][ADDR_W-1:0] base_i,
   input  logic [NUM_ROWS-1:0]             empty_i,
   output logic                            hit_o,
   output logic [IDX_W-1:0]                row_o
);
   logic [NUM_ROWS-1:0] in_row;

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_cmp
      assign in_row[r] = !empty_i[r] && (addr_i >= base_i[r]) && (addr_i < lim_i[r]);
   end

   // scan downwards so the lowest matching row is the last one written
   always_comb begin
      hit_o = 1'b0;
      row_o = '0;
      for (int r = NUM_ROWS - 1; r >= 0; r--) begin
         if (in_row[r]) begin
            hit_o = 1'b1;
            row_o = IDX_W'(r);
         end
      end
   end
endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder #(
   parameter int unsigned NUM_ROWS = dram_row_pkg::ROWS_DEF,
   parameter int unsigned BND_W    = dram_row_pkg::BND_W_DEF,
   parameter int unsigned SHIFT    = dram_row_pkg::SHIFT_DEF,
   parameter int unsigned ADDR_W   = dram_row_pkg::ADDR_W_DEF,
   parameter int unsigned IDX_W    = $clog2(NUM_ROWS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [BND_W-1:0]           wr_data,
   input  logic                       req_valid,
   input  logic [ADDR_W-1:0]          req_addr,
   output logic                       rsp_valid,
   output logic [IDX_W-1:0]           rsp_row,
   output logic                       rsp_hit,
   output logic [NUM_ROWS-1:0]        row_empty,
   output logic [NUM_ROWS*ADDR_W-1:0] row_base,
   output logic [NUM_ROWS*ADDR_W-1:0] row_last
);
   localparam int unsigned LIM_W = BND_W + SHIFT + 1;

   if (NUM_ROWS < 2) begin : g_bad_rows
      $error("dram_row_decoder: NUM_ROWS must be at least 2");
   end
   if (LIM_W > ADDR_W) begin : g_bad_width
      $error("dram_row_decoder: ADDR_W too narrow for the top-of-memory limit");
   end
   if (IDX_W < $clog2(NUM_ROWS)) begin : g_bad_idx
      $error("dram_row_decoder: IDX_W cannot number every row");
   end

   logic [NUM_ROWS-1:0][BND_W-1:0]  bnd;
   logic [NUM_ROWS-1:0][ADDR_W-1:0] lim, base, last;
   logic                            m_hit;
   logic [IDX_W-1:0]                m_row;

   drow_bnd_regs #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .bnd_o(bnd));

   drow_limit_chain #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .SHIFT(SHIFT),
                      .ADDR_W(ADDR_W)) u_chain (
      .bnd_i(bnd), .lim_o(lim), .base_o(base), .last_o(last), .empty_o(row_empty));

   drow_match #(.NUM_ROWS(NUM_ROWS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
      .addr_i(req_addr), .lim_i(lim), .base_i(base), .empty_i(row_empty),
      .hit_o(m_hit), .row_o(m_row));

   assign row_base = base;
   assign row_last = last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_row   <= '0;
         rsp_hit   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_row <= m_row;
            rsp_hit <= m_hit;
         end
      end
   end
endmodule

// File: rtl/dram_row_decoder_chk.sv
module dram_row_decoder_chk #(
   parameter int unsigned NUM_ROWS = 8,
   parameter int unsigned BND_W    = 8,
   parameter int unsigned IDX_W    = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [IDX_W-1:0]    wr_idx,
   input logic [BND_W-1:0]    wr_data,
   input logic                req_valid,
   input logic                rsp_valid,
   input logic [IDX_W-1:0]    rsp_row,
   input logic                rsp_hit,
   input logic [NUM_ROWS-1:0] row_empty
);
   // R8
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R8
   no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R6
   miss_row_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_row == '0));
   // R4
   hit_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> !(($past(row_empty) >> rsp_row) & 1'b1));
   // R2
   row0_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx == '0) && (wr_data != '0)) |=> !row_empty[0]);
   // R4
   row0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx == '0) && (wr_data == '0)) |=> row_empty[0]);
endmodule

bind dram_row_decoder dram_row_decoder_chk #(
   .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
   .req_valid(req_valid), .rsp_valid(rsp_valid), .rsp_row(rsp_row),
   .rsp_hit(rsp_hit), .row_empty(row_empty));

// File: tb/dram_row_decoder_tb.sv
module dram_row_decoder_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NR = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_idx = '0;
   logic [7:0]   wr_data = '0;
   logic         req_valid = 1'b0;
   logic [31:0]  req_addr = '0;
   logic         rsp_valid;
   logic [2:0]   rsp_row;
   logic         rsp_hit;
   logic [7:0]   row_empty;
   logic [255:0] row_base;
   logic [255:0] row_last;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // behavioural model state
   int     m_bnd [NR];
   longint m_lim [NR];
   longint m_base[NR];
   longint m_last[NR];
   bit     m_empty[NR];
   bit     e_valid;
   int     e_row;
   bit     e_hit;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_row_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
      .rsp_row(rsp_row), .rsp_hit(rsp_hit), .row_empty(row_empty),
      .row_base(row_base), .row_last(row_last));

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic void model_rows();
      longint run = 0;
      for (int r = 0; r < NR; r++) begin
         longint eff = longint'(m_bnd[r]) * 64'd8388608;
         if (run != 0 && m_bnd[r] == 0) eff = 64'd2147483648;
         m_empty[r] = (eff == run);
         m_lim[r]   = eff;
         m_base[r]  = m_empty[r] ? 0 : run;
         m_last[r]  = m_empty[r] ? 0 : eff - 1;
         run = eff;
      end
   endfunction

   function automatic void model_lookup(input longint a);
      e_hit = 0;
      e_row = 0;
      for (int r = 0; r < NR; r++) begin
         if (!e_hit && !m_empty[r] && a >= m_base[r] && a < m_lim[r]) begin
            e_hit = 1;
            e_row = r;
         end
      end
   endfunction

   task automatic check_static(input string tag);
      for (int r = 0; r < NR; r++) begin
         chk(tag, $sformatf("R4 empty[%0d]", r), longint'(row_empty[r]), longint'(m_empty[r]));
         chk(tag, $sformatf("R3 base[%0d]", r), longint'(row_base[r*32 +: 32]), m_base[r]);
         chk(tag, $sformatf("R3 last[%0d]", r), longint'(row_last[r*32 +: 32]), m_last[r]);
      end
   endtask

   // one clock: drive at negedge, model at posedge, compare at next negedge
   task automatic step(input string tag, input bit rq, input longint a,
                       input bit we, input int idx, input int d);
      req_valid = rq;
      req_addr  = a[31:0];
      wr_en     = we;
      wr_idx    = idx[2:0];
      wr_data   = d[7:0];
      @(posedge clk);
      model_rows();
      e_valid = rq;
      if (rq) model_lookup(a);   // R9: decode against pre-write contents
      if (we) m_bnd[idx] = d;
      model_rows();
      @(negedge clk);
      req_valid = 0;
      wr_en = 0;
      chk(tag, "R8 rsp_valid", longint'(rsp_valid), longint'(e_valid));
      if (e_valid) begin
         chk(tag, "rsp_hit", longint'(rsp_hit), longint'(e_hit));
         chk(tag, "rsp_row", longint'(rsp_row), longint'(e_row));
      end
      check_static(tag);
   endtask

   task automatic load(input string tag, input int v0, input int v1, input int v2, input int v3,
                       input int v4, input int v5, input int v6, input int v7);
      int vals[NR];
      vals = '{v0, v1, v2, v3, v4, v5, v6, v7};
      for (int r = 0; r < NR; r++) step(tag, 0, 0, 1, r, vals[r]);
   endtask

   localparam longint MB8 = 64'd8388608;

   initial begin
      for (int r = 0; r < NR; r++) m_bnd[r] = 0;
      model_rows();
      repeat (3) @(negedge clk);
      // R1: state while reset is held
      chk("R1", "rsp_valid", longint'(rsp_valid), 0);
      check_static("R1");
      rst_n = 1'b1;
      @(negedge clk);
      step("R1", 1, 0, 0, 0, 0);
      step("R1", 1, 64'h1234_5678, 0, 0, 0);

      // R2 R4 R5: rows 1 and 3 empty, row 5 reaches the 2 GiB top, 6 and 7 empty
      load("R2", 2, 2, 6, 6, 10, 0, 0, 0);
      step("R2", 1, 0, 0, 0, 0);
      step("R3", 1, 2*MB8 - 1, 0, 0, 0);
      step("R4", 1, 2*MB8, 0, 0, 0);
      step("R3", 1, 6*MB8, 0, 0, 0);
      step("R3", 1, 10*MB8 - 1, 0, 0, 0);
      step("R5", 1, 10*MB8, 0, 0, 0);
      step("R5", 1, 64'h7FFF_FFFF, 0, 0, 0);
      step("R6", 1, 64'h8000_0000, 0, 0, 0);
      step("R6", 1, 64'hFFFF_FFFF, 0, 0, 0);

      // R8: idle cycles give no response
      step("R8", 0, 0, 0, 0, 0);
      step("R8", 1, 5*MB8, 0, 0, 0);
      step("R8", 0, 5*MB8, 0, 0, 0);

      // R6: no top row, address past the final limit misses
      load("R6", 2, 2, 6, 6, 10, 10, 10, 10);
      step("R6", 1, 10*MB8, 0, 0, 0);
      step("R6", 1, 10*MB8 - 1, 0, 0, 0);

      // R7: out-of-order limits create an overlap; lowest row wins
      load("R7", 4, 2, 6, 6, 6, 6, 6, 6);
      step("R7", 1, 20*MB8/8 + 64'd3, 0, 0, 0);
      step("R7", 1, 40*1024*1024, 0, 0, 0);
      step("R7", 1, 33*1024*1024, 0, 0, 0);

      // R2 R5: full-scale register then zero gives 2 GiB top for row 1
      load("R2", 255, 0, 0, 0, 0, 0, 0, 0);
      step("R2", 1, 64'h7F7F_FFFF, 0, 0, 0);
      step("R5", 1, 64'h7F80_0000, 0, 0, 0);

      // R9: request alongside a write uses the old value
      step("R9", 1, 64'h100, 1, 0, 0);
      step("R9", 1, 64'h100, 0, 0, 0);
      step("R9", 1, 64'h100, 1, 0, 1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule